// File: doc/BRIEF.md
# Ternary Ripple-Carry Adder

This block adds two unsigned base-3 numbers of N digits (default N = 5) and a binary carry-in. It returns an N-digit base-3 sum and a binary carry-out. Each base-3 digit (trit) travels on two binary wires as a thermometer code. Every digit position turns both operand digits into one-hot flags. It then works out its sum and carry twice, once for an incoming carry of 0 and once for 1. The carry arriving from the digit below picks one of the two results. The carry-1 sum is not computed separately: it is the carry-0 sum with its value raised by one modulo 3.

Carries pass from the least significant digit upward. The encoded result passes through an output stage. With `REG_OUT = 1` (the default) that stage is a register with synchronous active-high reset. With `REG_OUT = 0` it is a plain wire. An operand digit that holds the one unused code pattern raises an error output and is counted as the value 2.

Top module: `tern_cp_adder`

## Requirements
- R1: Digit i of a bus occupies bits [2i+1:2i], and digit 0 is the least significant. Bit 2i means "value at least 1" and bit 2i+1 means "value equals 2". The valid codes are 00 = 0, 01 = 1 and 11 = 2.
- R2: `sum_o` holds (A + B + cin) mod 3^N, where A and B are the base-3 values of `a_i` and `b_i`.
- R3: `cout_o` is 1 exactly when A + B + cin is 3^N or more.
- R4: If any operand digit holds the code 10, `code_err_o` is 1 and that digit counts as 2 in R2 and R3. Otherwise `code_err_o` is 0.
- R5: No digit of `sum_o` ever holds the code 10.
- R6: With REG_OUT = 1, all outputs show the result of the inputs sampled at the previous rising clock edge. A new input has no effect on the outputs before the next edge.
- R7: With REG_OUT = 1, a clock edge with `rst` high clears `sum_o`, `cout_o` and `code_err_o` to zero, whatever the inputs are.
- R8: A carry ripples through every digit position. For example, all digits 2, plus 0, plus carry-in 1 gives sum 0 with carry-out 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 2*N | Operand A, N thermometer-coded digits |
| b_i | input | 2*N | Operand B, N thermometer-coded digits |
| cin_i | input | 1 | Binary carry-in to digit 0 |
| sum_o | output | 2*N | Sum, N thermometer-coded digits |
| cout_o | output | 1 | Binary carry-out of the top digit |
| code_err_o | output | 1 | An operand digit held the unused code |

## Verification
The assertions check three things on every cycle. Each digit cell must satisfy a + b + cin = s + 3*cout. No output digit may hold the unused code. The registered error flag and a zero-plus-zero result must follow the previous cycle's inputs.

Some behaviour only the bench's scenarios can show:
- full-width modular wrap and carry-out against base-3 integer arithmetic, over every N = 2 operand pair and random N = 5 vectors;
- the exact bit placement of the code;
- the reset values;
- that a changed input has not reached the outputs before the clock edge.

// File: rtl/tern_pkg.sv
package tern_pkg;

    // Thermometer digit: ge1 = value >= 1, ge2 = value == 2
    typedef struct packed {
        logic ge2;
        logic ge1;
    } trit_t;

    typedef struct packed {
        logic is2;
        logic is1;
        logic is0;
    } onehot_t;

    // The unused code (ge2 without ge1) is taken as 2
    function automatic onehot_t trit_to_onehot(trit_t t);
        onehot_t o;
        o.is2 = t.ge2;
        o.is1 = t.ge1 & ~t.ge2;
        o.is0 = ~t.ge1 & ~t.ge2;
        return o;
    endfunction

    // Raise a one-hot digit by one, modulo 3
    function automatic onehot_t rotate_up(onehot_t s);
        onehot_t o;
        o.is0 = s.is2;
        o.is1 = s.is0;
        o.is2 = s.is1;
        return o;
    endfunction

    // Output lines: zero_ln high for 0, le1_ln high for 0 or 1
    function automatic trit_t lines_to_trit(logic zero_ln, logic le1_ln);
        trit_t t;
        t.ge1 = ~zero_ln;
        t.ge2 = ~le1_ln;
        return t;
    endfunction

    function automatic int onehot_val(onehot_t o);
        return o.is2 ? 2 : (o.is1 ? 1 : 0);
    endfunction

    function automatic int trit_val(trit_t t);
        return t.ge2 ? 2 : (t.ge1 ? 1 : 0);
    endfunction

endpackage

// File: rtl/tern_decode.sv
module tern_decode
    import tern_pkg::*;
(
    input  trit_t   t_i,
    output onehot_t oh_o,
    output logic    bad_o
);
    always_comb begin
        oh_o  = trit_to_onehot(t_i);
        bad_o = t_i.ge2 & ~t_i.ge1;
    end
endmodule

// File: rtl/tern_digit_cell.sv
module tern_digit_cell
    import tern_pkg::*;
(
    input  onehot_t a_i,
    input  onehot_t b_i,
    input  logic    cin_i,
    output trit_t   s_o,
    output logic    cout_o
);
    onehot_t s_c0;
    onehot_t s_c1;
    onehot_t s_sel;
    logic    c_c0;
    logic    c_c1;

    always_comb begin
        // Result for carry-in 0
        s_c0.is0 = (a_i.is0 & b_i.is0) | (a_i.is1 & b_i.is2) | (a_i.is2 & b_i.is1);
        s_c0.is1 = (a_i.is0 & b_i.is1) | (a_i.is1 & b_i.is0) | (a_i.is2 & b_i.is2);
        s_c0.is2 = (a_i.is0 & b_i.is2) | (a_i.is1 & b_i.is1) | (a_i.is2 & b_i.is0);
        c_c0     = (a_i.is1 & b_i.is2) | (a_i.is2 & b_i.is1) | (a_i.is2 & b_i.is2);
        // Result for carry-in 1: the carry-0 sum raised by one
        s_c1     = rotate_up(s_c0);
        c_c1     = a_i.is2 | b_i.is2 | (a_i.is1 & b_i.is1);
        // The incoming carry picks one result
        s_sel    = cin_i ? s_c1 : s_c0;
        cout_o   = cin_i ? c_c1 : c_c0;
        s_o      = lines_to_trit(s_sel.is0, s_sel.is0 | s_sel.is1);
    end

    always_comb begin
        if (!$isunknown({a_i, b_i, cin_i})) begin
            AST_CELL_ARITH: assert (onehot_val(a_i) + onehot_val(b_i) + int'(cin_i)
                                    == trit_val(s_o) + 3 * int'(cout_o)); // R2
        end
    end
endmodule

// File: rtl/tern_out_stage.sv
module tern_out_stage #(
    parameter int W       = 10,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sum_d,
    input  logic         cout_d,
    input  logic         err_d,
    output logic [W-1:0] sum_q,
    output logic         cout_q,
    output logic         err_q
);
    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    sum_q  <= '0;
                    cout_q <= 1'b0;
                    err_q  <= 1'b0;
                end else begin
                    sum_q  <= sum_d;
                    cout_q <= cout_d;
                    err_q  <= err_d;
                end
            end
        end else begin : g_wire
            assign sum_q  = sum_d;
            assign cout_q = cout_d;
            assign err_q  = err_d;
        end
    endgenerate
endmodule

// File: rtl/tern_cp_adder.sv
module tern_cp_adder
    import tern_pkg::*;
#(
    parameter int N       = 5,
    parameter bit REG_OUT = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [2*N-1:0] a_i,
    input  logic [2*N-1:0] b_i,
    input  logic           cin_i,
    output logic [2*N-1:0] sum_o,
    output logic           cout_o,
    output logic           code_err_o
);
    localparam int W = 2 * N;

    logic [N:0]   carry;
    logic [N-1:0] bad_a;
    logic [N-1:0] bad_b;
    logic [W-1:0] sum_c;

    assign carry[0] = cin_i;

    generate
        for (genvar i = 0; i < N; i++) begin : g_digit
            onehot_t oh_a;
            onehot_t oh_b;
            trit_t   s_t;

            tern_decode u_dec_a (.t_i(trit_t'(a_i[2*i +: 2])), .oh_o(oh_a), .bad_o(bad_a[i]));
            tern_decode u_dec_b (.t_i(trit_t'(b_i[2*i +: 2])), .oh_o(oh_b), .bad_o(bad_b[i]));

            tern_digit_cell u_cell (
                .a_i   (oh_a),
                .b_i   (oh_b),
                .cin_i (carry[i]),
                .s_o   (s_t),
                .cout_o(carry[i+1])
            );
            assign sum_c[2*i +: 2] = s_t;

            AST_SUM_LEGAL: assert property (@(posedge clk) disable iff (rst)
                !(sum_o[2*i+1] & ~sum_o[2*i])); // R5
        end
    endgenerate

    tern_out_stage #(.W(W), .REG_OUT(REG_OUT)) u_out (
        .clk   (clk),
        .rst   (rst),
        .sum_d (sum_c),
        .cout_d(carry[N]),
        .err_d (|{bad_a, bad_b}),
        .sum_q (sum_o),
        .cout_q(cout_o),
        .err_q (code_err_o)
    );

    generate
        if (REG_OUT) begin : g_chk
            logic [W-1:0] ge2_only;
            always_comb begin
                for (int k = 0; k < N; k++) begin
                    ge2_only[2*k]   = a_i[2*k+1] & ~a_i[2*k];
                    ge2_only[2*k+1] = b_i[2*k+1] & ~b_i[2*k];
                end
            end

            AST_ERR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
                !rst |=> (code_err_o == $past(|ge2_only))); // R4

            AST_ZERO_PLUS_ZERO: assert property (@(posedge clk) disable iff (rst)
                (a_i == '0 && b_i == '0 && !cin_i) |=> (sum_o == '0 && !cout_o)); // R6
        end
    endgenerate
endmodule

// File: tb/sim_tern_cp_adder.sv
module sim_tern_cp_adder;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] a5 = '0, b5 = '0, s5;
    logic       c5 = 1'b0, co5, er5;
    logic [3:0] a2 = '0, b2 = '0, s2;
    logic       c2 = 1'b0, co2, er2;

    int n_chk = 0;
    int n_err = 0;
    int seed_dummy;

    always #(CLK_PERIOD/2) clk = ~clk;

    tern_cp_adder #(.N(5), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst(rst), .a_i(a5), .b_i(b5), .cin_i(c5),
        .sum_o(s5), .cout_o(co5), .code_err_o(er5));

    tern_cp_adder #(.N(2), .REG_OUT(1'b1)) u1 (
        .clk(clk), .rst(rst), .a_i(a2), .b_i(b2), .cin_i(c2),
        .sum_o(s2), .cout_o(co2), .code_err_o(er2));

    // Encoding per R1: 00 = 0, 01 = 1, 11 = 2, digit 0 in the low bits
    function automatic logic [9:0] enc(int v, int n);
        logic [9:0] r = '0;
        for (int i = 0; i < n; i++) begin
            int d = v % 3;
            r[2*i +: 2] = (d == 0) ? 2'b00 : ((d == 1) ? 2'b01 : 2'b11);
            v = v / 3;
        end
        return r;
    endfunction

    // Per R4 the code 10 counts as 2
    function automatic int dec(logic [9:0] x, int n);
        int v = 0;
        for (int i = n - 1; i >= 0; i--) begin
            int d = x[2*i+1] ? 2 : (x[2*i] ? 1 : 0);
            v = v * 3 + d;
        end
        return v;
    endfunction

    function automatic int has_bad(logic [9:0] x, int n);
        int r = 0;
        for (int i = 0; i < n; i++) if (x[2*i+1] && !x[2*i]) r = 1;
        return r;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run5(logic [9:0] a, logic [9:0] b, logic ci);
        int tot;
        @(negedge clk);
        a5 = a; b5 = b; c5 = ci;
        @(posedge clk);
        #1;
        tot = dec(a, 5) + dec(b, 5) + int'(ci);
        chk("R2 sum5", dec(s5, 5), tot % 243);
        chk("R3 cout5", int'(co5), int'(tot >= 243));
        chk("R4 err5", int'(er5), (has_bad(a, 5) | has_bad(b, 5)));
        chk("R5 legal5", has_bad(s5, 5), 0);
    endtask

    task automatic run2(logic [3:0] a, logic [3:0] b, logic ci);
        int tot;
        @(negedge clk);
        a2 = a; b2 = b; c2 = ci;
        @(posedge clk);
        #1;
        tot = dec({6'b0, a}, 2) + dec({6'b0, b}, 2) + int'(ci);
        chk("R2 sum2", dec({6'b0, s2}, 2), tot % 9);
        chk("R3 cout2", int'(co2), int'(tot >= 9));
        chk("R5 legal2", has_bad({6'b0, s2}, 2), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'h5eed);

        // R7: reset with nonzero inputs gives zero outputs
        a5 = enc(200, 5); b5 = enc(100, 5); c5 = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R7 sum", int'(s5), 0);
        chk("R7 cout", int'(co5), 0);
        chk("R7 err", int'(er5), 0);
        @(negedge clk);
        rst = 1'b0;

        // R1: raw bit placement, 1 + 1 = 2 in digit 0, 2 + 0 + 1 carries into digit 1
        run5(enc(1, 5), enc(1, 5), 1'b0);
        chk("R1 raw 2", int'(s5), int'(10'b0000000011));
        run5(enc(2, 5), enc(0, 5), 1'b1);
        chk("R1 raw 3", int'(s5), int'(10'b0000000100));

        // R8: ripple through every digit
        run5(enc(242, 5), enc(0, 5), 1'b1);
        chk("R8 sum", int'(s5), 0);
        chk("R8 cout", int'(co5), 1);
        run5(enc(242, 5), enc(242, 5), 1'b1);
        chk("R8 max", dec(s5, 5), 242);

        // R4: unused code in one digit
        run5(10'b0000100000, enc(1, 5), 1'b0);
        chk("R4 flag", int'(er5), 1);
        run5(enc(5, 5), 10'b1000000000, 1'b1);

        // R6: a new input has not reached the outputs before the edge
        @(negedge clk);
        a5 = enc(7, 5); b5 = enc(9, 5); c5 = 1'b0;
        #1;
        chk("R6 hold", int'(er5), 1);
        @(posedge clk);
        #1;
        chk("R6 update", dec(s5, 5), 16);

        // Random N = 5
        for (int k = 0; k < 400; k++) begin
            logic [9:0] ra = enc(int'($urandom % 243), 5);
            logic [9:0] rb = enc(int'($urandom % 243), 5);
            if (($urandom % 16) == 0) ra[2*($urandom % 5) +: 2] = 2'b10;
            run5(ra, rb, 1'($urandom % 2));
        end

        // Exhaustive N = 2
        for (int x = 0; x < 9; x++)
            for (int y = 0; y < 9; y++)
                for (int ci = 0; ci < 2; ci++) begin
                    logic [9:0] ea = enc(x, 2);
                    logic [9:0] eb = enc(y, 2);
                    run2(ea[3:0], eb[3:0], 1'(ci));
                end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule